// File: doc/BRIEF.md
# Handshaked FIFO Port with Down-Counting Transfer Length

This block is the host-facing data path of a peripheral controller. A 16-entry byte FIFO sits between a processor-style register bus and a device-side byte stream that uses valid and ready. Software reaches the block's registers with a chip select and read or write strobes. In programmed I/O it also moves FIFO bytes through the data register.

For bulk moves, software loads a stored transfer length and then writes a command with bit 7 set. That command copies the length into a separate working counter and starts the request/acknowledge handshake. The block raises its request line when a byte can move in the programmed direction. An external mover answers with an active-low acknowledge qualified by a read or write strobe. Each qualified acknowledge moves one byte and counts down. When the count runs out, the request drops and an interrupt is raised. Misuse of the select and acknowledge lines is reported as a gross error.

A register access completes on the clock edge at which its strobe is first seen high again. It uses the select, acknowledge, address and write data sampled on the last cycle the strobe was low. Read data is combinational while the strobe is low.

Top module: `dma_fifo_port`

## Requirements
- R1: After reset, dreq and irq are low, the status register (address 4) reads 0x00 and both working-count bytes (addresses 2 and 3) read 0x00.
- R2: With chip select, a write to address 0 pushes a byte and a read from address 0 pops bytes in arrival order. Status bits [4:0] give the FIFO level, bit 6 the active-transfer flag and bit 5 the direction.
- R3: Writes to addresses 2 (low byte) and 3 (high byte) set only the stored count, and reads of 2 and 3 return the working counter. Only a command write (address 1) with bit 7 set copies the stored count into the working counter, and a command with bit 7 clear leaves the working counter unchanged.
- R4: Command bit 0 = 1 selects the read direction, in which the device stream fills the FIFO. There dreq is high only while a transfer is active and the FIFO holds at least one byte.
- R5: Command bit 0 = 0 selects the write direction, in which the FIFO drains to the device stream. There dreq is high only while a transfer is active and the FIFO is not full, and acknowledged write bytes reach the device in order.
- R6: Each completed access with dack_n low and a read or write strobe moves one FIFO byte and decrements the working counter by one. A dack_n pulse with no strobe changes nothing.
- R7: When the working counter reaches zero, the transfer stops, dreq falls, irq rises, status bit 7 is set and interrupt-status (address 5) bit 0 is set.
- R8: A chip-select read of address 5 returns the interrupt status, then clears both of its bits and irq.
- R9: An access with chip select and dack_n both low sets interrupt-status bit 1 and raises irq. It moves no byte and leaves the counter unchanged.
- R10: During an active transfer, an acknowledged access whose strobe opposes the programmed direction sets interrupt-status bit 1 and raises irq. It moves no byte and leaves the counter unchanged.
- R11: A bit-7 command with a stored count of zero gives terminal count at once. A command with bit 7 clear stops any active transfer without raising irq.
- R12: An acknowledged access while no transfer is active, or while dreq is low, moves no byte and leaves the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Register chip select, active low |
| dack_n | input | 1 | FIFO acknowledge, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| dreq | output | 1 | Transfer request |
| irq | output | 1 | Interrupt pending |
| dev_in_valid | input | 1 | Device byte offered to the FIFO |
| dev_in_data | input | 8 | Device byte |
| dev_in_ready | output | 1 | FIFO accepts the device byte |
| dev_out_valid | output | 1 | FIFO byte offered to the device |
| dev_out_data | output | 8 | FIFO byte for the device |
| dev_out_ready | input | 1 | Device takes the byte |

## Verification
The properties assume that read and write strobes are never low in the same cycle. They also assume that a strobe falls only after select, acknowledge and address are settled, and that these stay steady until the strobe rises. The bench drives every access as a single-cycle strobe that starts and ends on falling clock edges, with all qualifiers held for that whole cycle. It never drives both strobes at once. It offers device bytes only when the FIFO has space and the direction accepts them.

// File: rtl/dma_fifo_port.sv
module dma_fifo_port #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int CW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          dack_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [2:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          dreq,
  output logic          irq,
  input  logic          dev_in_valid,
  input  logic [DW-1:0] dev_in_data,
  output logic          dev_in_ready,
  output logic          dev_out_valid,
  output logic [DW-1:0] dev_out_data,
  input  logic          dev_out_ready
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_LVL = (AW+1)'(DEPTH);
  localparam int PADW = DW - (AW + 1) - 3;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   level;
  logic          empty, full;

  logic          s_rd, s_wr, s_cs, s_dack;
  logic [2:0]    s_addr;
  logic [DW-1:0] s_wd;

  logic [DW-1:0] cmd;
  logic          dir, active, tc_flag, gross_flag;
  logic [CW-1:0] cnt_store, cnt_work;

  logic rd_done, wr_done, done, illegal, cs_acc, dack_acc;
  logic dir_ok, mismatch, dma_xfer, cmd_load;
  logic host_push, host_pop, dev_push, dev_pop, push, pop;
  logic [DW-1:0] push_data;

  assign empty = (level == '0);
  assign full  = (level == FULL_LVL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_rd <= 1'b0; s_wr <= 1'b0; s_cs <= 1'b0; s_dack <= 1'b0;
      s_addr <= '0; s_wd <= '0;
    end else begin
      s_rd   <= ~rd_n;
      s_wr   <= ~wr_n;
      s_cs   <= ~cs_n;
      s_dack <= ~dack_n;
      s_addr <= addr;
      s_wd   <= wdata;
    end
  end

  assign rd_done  = s_rd & rd_n;
  assign wr_done  = s_wr & wr_n;
  assign done     = rd_done | wr_done;
  assign illegal  = done & s_cs & s_dack;
  assign cs_acc   = done & s_cs & ~s_dack;
  assign dack_acc = done & s_dack & ~s_cs;
  assign dir_ok   = rd_done ? dir : ~dir;
  assign mismatch = dack_acc & active & ~dir_ok;
  assign dma_xfer = dack_acc & active & dir_ok & dreq;
  assign cmd_load = cs_acc & wr_done & (s_addr == 3'd1) & s_wd[DW-1];

  assign dreq = active & (dir ? ~empty : ~full);
  assign irq  = tc_flag | gross_flag;

  assign host_pop  = (cs_acc & rd_done & (s_addr == 3'd0) & ~empty) | (dma_xfer & rd_done);
  assign host_push = (cs_acc & wr_done & (s_addr == 3'd0) & ~full)  | (dma_xfer & wr_done);

  assign dev_in_ready  = dir & ~full & ~host_push;
  assign dev_out_valid = ~dir & ~empty & ~host_pop;
  assign dev_out_data  = mem[rptr];
  assign dev_push = dev_in_valid & dev_in_ready;
  assign dev_pop  = dev_out_valid & dev_out_ready;

  assign push      = host_push | dev_push;
  assign pop       = host_pop | dev_pop;
  assign push_data = host_push ? s_wd : dev_in_data;

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0; rptr <= '0; level <= '0;
    end else begin
      if (push) wptr <= wptr + 1'b1;
      if (pop)  rptr <= rptr + 1'b1;
      case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd <= '0; dir <= 1'b0; active <= 1'b0;
      tc_flag <= 1'b0; gross_flag <= 1'b0;
      cnt_store <= '0; cnt_work <= '0;
    end else begin
      if (cs_acc & rd_done & (s_addr == 3'd5)) begin
        tc_flag    <= 1'b0;
        gross_flag <= 1'b0;
      end
      if (cs_acc & wr_done) begin
        case (s_addr)
          3'd1: begin
            cmd <= s_wd;
            dir <= s_wd[0];
            if (s_wd[DW-1]) begin
              cnt_work <= cnt_store;
              if (cnt_store == '0) begin
                active  <= 1'b0;
                tc_flag <= 1'b1;
              end else begin
                active <= 1'b1;
              end
            end else begin
              active <= 1'b0;
            end
          end
          3'd2: cnt_store[7:0]    <= s_wd;
          3'd3: cnt_store[CW-1:8] <= s_wd[CW-9:0];
          default: ;
        endcase
      end
      if (dma_xfer) begin
        cnt_work <= cnt_work - 1'b1;
        if (cnt_work == CW'(1)) begin
          active  <= 1'b0;
          tc_flag <= 1'b1;
        end
      end
      if (illegal | mismatch) gross_flag <= 1'b1;
    end
  end

  always_comb begin
    rdata = '0;
    if (!dack_n) begin
      rdata = mem[rptr];
    end else begin
      case (addr)
        3'd0: rdata = mem[rptr];
        3'd1: rdata = cmd;
        3'd2: rdata = cnt_work[7:0];
        3'd3: rdata = DW'(cnt_work[CW-1:8]);
        3'd4: rdata = {irq, active, dir, {PADW{1'b0}}, level};
        3'd5: rdata = {{(DW-2){1'b0}}, gross_flag, tc_flag};
        default: rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/dma_fifo_port_chk.sv
module dma_fifo_port_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     dreq,
  input logic [CW-1:0]            cnt_work,
  input logic                     tc_flag,
  input logic                     gross_flag,
  input logic [$clog2(DEPTH):0]   level,
  input logic                     illegal,
  input logic                     cmd_load
);
  a_r7_zero_no_dreq: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_work == '0) |-> !dreq);

  a_r6_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_work != $past(cnt_work)) && !$past(cmd_load)) |-> (cnt_work == $past(cnt_work) - 1'b1));

  a_r9_illegal_flag: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> gross_flag);

  a_r9_illegal_count: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> $stable(cnt_work));

  a_r7_tc_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tc_flag) |-> (cnt_work == '0));

  always @(posedge clk) begin
    if (rst_n) a_r2_level_bound: assert (int'(level) <= DEPTH);
  end
endmodule

bind dma_fifo_port dma_fifo_port_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .dreq(dreq), .cnt_work(cnt_work),
  .tc_flag(tc_flag), .gross_flag(gross_flag), .level(level),
  .illegal(illegal), .cmd_load(cmd_load)
);

// File: tb/sim_dma_fifo_port.sv
module sim_dma_fifo_port;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, dack_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic dreq, irq;
  logic dev_in_valid = 1'b0, dev_in_ready;
  logic [7:0] dev_in_data = '0, dev_out_data;
  logic dev_out_valid, dev_out_ready = 1'b0;

  int checks = 0, errors = 0, cycles = 0, out_cnt = 0;
  logic [7:0] out_q [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_fifo_port u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .dack_n(dack_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .dreq(dreq), .irq(irq),
    .dev_in_valid(dev_in_valid), .dev_in_data(dev_in_data), .dev_in_ready(dev_in_ready),
    .dev_out_valid(dev_out_valid), .dev_out_data(dev_out_data), .dev_out_ready(dev_out_ready)
  );

  always @(posedge clk) begin
    if (dev_out_valid && dev_out_ready && out_cnt < 64) begin
      out_q[out_cnt] = dev_out_data;
      out_cnt = out_cnt + 1;
    end
  end

  always @(posedge clk) begin
    cycles = cycles + 1;
    if (cycles > 50000) begin
      errors = errors + 1;
      $display("FAIL watchdog: got %0d cycles exp below 50000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks = checks + 1;
    if (got !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic cs_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); cs_n = 0; wr_n = 0; addr = a; wdata = d;
    @(negedge clk); cs_n = 1; wr_n = 1;
    @(negedge clk);
  endtask

  task automatic cs_rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); cs_n = 0; rd_n = 0; addr = a;
    #1 v = rdata;
    @(negedge clk); cs_n = 1; rd_n = 1;
    @(negedge clk);
  endtask

  task automatic dk_rd(output logic [7:0] v);
    @(negedge clk); dack_n = 0; rd_n = 0;
    #1 v = rdata;
    @(negedge clk); dack_n = 1; rd_n = 1;
    @(negedge clk);
  endtask

  task automatic dk_wr(input logic [7:0] d);
    @(negedge clk); dack_n = 0; wr_n = 0; wdata = d;
    @(negedge clk); dack_n = 1; wr_n = 1;
    @(negedge clk);
  endtask

  task automatic dev_push(input logic [7:0] d);
    @(negedge clk); dev_in_valid = 1; dev_in_data = d;
    @(negedge clk); dev_in_valid = 0;
  endtask

  task automatic set_count(input logic [15:0] c);
    cs_wr(3'd2, c[7:0]);
    cs_wr(3'd3, c[15:8]);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 dreq", {15'd0, dreq}, 16'd0);
    check("R1 irq", {15'd0, irq}, 16'd0);
    cs_rd(3'd4, v); check("R1 status", {8'd0, v}, 16'h00);
    cs_rd(3'd2, v); check("R1 count lo", {8'd0, v}, 16'h00);
    cs_rd(3'd3, v); check("R1 count hi", {8'd0, v}, 16'h00);
  endtask

  task automatic t_pio();
    logic [7:0] v;
    cs_wr(3'd1, 8'h00);
    cs_wr(3'd0, 8'h11); cs_wr(3'd0, 8'h22); cs_wr(3'd0, 8'h33);
    cs_rd(3'd4, v); check("R2 level 3", {8'd0, v}, 16'h03);
    cs_rd(3'd0, v); check("R2 pop 1", {8'd0, v}, 16'h11);
    cs_rd(3'd0, v); check("R2 pop 2", {8'd0, v}, 16'h22);
    cs_rd(3'd4, v); check("R2 level 1", {8'd0, v}, 16'h01);
    cs_rd(3'd0, v); check("R2 pop 3", {8'd0, v}, 16'h33);
  endtask

  task automatic t_dma_read();
    logic [7:0] v;
    set_count(16'd3);
    cs_rd(3'd2, v); check("R3 stored not working", {8'd0, v}, 16'h00);
    cs_wr(3'd1, 8'h81);
    cs_rd(3'd2, v); check("R3 loaded", {8'd0, v}, 16'h03);
    cs_rd(3'd4, v); check("R4 status active rd", {8'd0, v}, 16'h60);
    check("R4 dreq empty", {15'd0, dreq}, 16'd0);
    dev_push(8'hA1); dev_push(8'hA2); dev_push(8'hA3); dev_push(8'hA4);
    check("R4 dreq data", {15'd0, dreq}, 16'd1);
    @(negedge clk); dack_n = 0; @(negedge clk); dack_n = 1; @(negedge clk);
    cs_rd(3'd2, v); check("R6 no strobe", {8'd0, v}, 16'h03);
    dk_rd(v); check("R6 byte 1", {8'd0, v}, 16'hA1);
    cs_rd(3'd2, v); check("R6 count 2", {8'd0, v}, 16'h02);
    dk_rd(v); check("R6 byte 2", {8'd0, v}, 16'hA2);
    dk_rd(v); check("R6 byte 3", {8'd0, v}, 16'hA3);
    check("R7 dreq off", {15'd0, dreq}, 16'd0);
    check("R7 irq", {15'd0, irq}, 16'd1);
    cs_rd(3'd4, v); check("R7 status", {8'd0, v}, 16'hA1);
    cs_rd(3'd5, v); check("R7 tc bit", {8'd0, v}, 16'h01);
    check("R8 irq cleared", {15'd0, irq}, 16'd0);
    cs_rd(3'd5, v); check("R8 bits cleared", {8'd0, v}, 16'h00);
    dk_rd(v);
    cs_rd(3'd4, v); check("R12 inactive ignored", {8'd0, v}, 16'h21);
    cs_rd(3'd0, v); check("R2 pio in rd dir", {8'd0, v}, 16'hA4);
  endtask

  task automatic t_dma_write();
    logic [7:0] v;
    set_count(16'd2);
    cs_wr(3'd1, 8'h80);
    check("R5 dreq room", {15'd0, dreq}, 16'd1);
    dk_wr(8'h55); dk_wr(8'h66);
    check("R7 wr irq", {15'd0, irq}, 16'd1);
    check("R7 wr dreq off", {15'd0, dreq}, 16'd0);
    cs_rd(3'd5, v); check("R7 wr tc", {8'd0, v}, 16'h01);
    @(negedge clk); dev_out_ready = 1; repeat (4) @(negedge clk); dev_out_ready = 0;
    check("R5 out count", 16'(out_cnt), 16'd2);
    check("R5 out 1", {8'd0, out_q[0]}, 16'h55);
    check("R5 out 2", {8'd0, out_q[1]}, 16'h66);
    set_count(16'd20);
    cs_wr(3'd1, 8'h80);
    for (int i = 0; i < 16; i++) dk_wr(8'(8'h10 + i));
    check("R5 dreq full", {15'd0, dreq}, 16'd0);
    cs_rd(3'd4, v); check("R5 status full", {8'd0, v}, 16'h50);
    cs_rd(3'd2, v); check("R6 count 4", {8'd0, v}, 16'h04);
    dk_wr(8'hEE);
    cs_rd(3'd2, v); check("R12 full ignored", {8'd0, v}, 16'h04);
    cs_wr(3'd1, 8'h00);
    cs_rd(3'd4, v); check("R11 stop", {8'd0, v}, 16'h10);
    check("R11 stop no irq", {15'd0, irq}, 16'd0);
    @(negedge clk); dev_out_ready = 1; repeat (20) @(negedge clk); dev_out_ready = 0;
    check("R5 fill out count", 16'(out_cnt), 16'd18);
    for (int i = 0; i < 16; i++) check("R5 fill order", {8'd0, out_q[2+i]}, 16'(8'h10 + i));
  endtask

  task automatic t_errors();
    logic [7:0] v;
    set_count(16'd5);
    cs_wr(3'd1, 8'h81);
    dev_push(8'hB0);
    @(negedge clk); cs_n = 0; dack_n = 0; rd_n = 0; addr = 3'd0;
    @(negedge clk); cs_n = 1; dack_n = 1; rd_n = 1;
    @(negedge clk);
    check("R9 irq", {15'd0, irq}, 16'd1);
    cs_rd(3'd2, v); check("R9 count kept", {8'd0, v}, 16'h05);
    cs_rd(3'd4, v); check("R9 fifo kept", {8'd0, v}, 16'hE1);
    cs_rd(3'd5, v); check("R9 gross bit", {8'd0, v}, 16'h02);
    dk_wr(8'h77);
    check("R10 irq", {15'd0, irq}, 16'd1);
    cs_rd(3'd2, v); check("R10 count kept", {8'd0, v}, 16'h05);
    cs_rd(3'd4, v); check("R10 fifo kept", {8'd0, v}, 16'hE1);
    cs_rd(3'd5, v); check("R10 gross bit", {8'd0, v}, 16'h02);
    cs_wr(3'd1, 8'h01);
    cs_rd(3'd0, v); check("R10 byte intact", {8'd0, v}, 16'hB0);
  endtask

  task automatic t_load();
    logic [7:0] v;
    set_count(16'h1234);
    cs_wr(3'd1, 8'h00);
    cs_rd(3'd2, v); check("R3 pio no load", {8'd0, v}, 16'h05);
    cs_wr(3'd1, 8'h80);
    cs_rd(3'd3, v); check("R3 hi loaded", {8'd0, v}, 16'h12);
    cs_rd(3'd2, v); check("R3 lo loaded", {8'd0, v}, 16'h34);
    cs_wr(3'd1, 8'h00);
    set_count(16'h0000);
    cs_wr(3'd1, 8'h80);
    check("R11 zero irq", {15'd0, irq}, 16'd1);
    check("R11 zero dreq", {15'd0, dreq}, 16'd0);
    cs_rd(3'd5, v); check("R11 zero tc", {8'd0, v}, 16'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_pio();
    t_dma_read();
    t_dma_write();
    t_errors();
    t_load();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule